// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative address translation buffer for 32-bit virtual addresses. Every slot describes a pair of adjacent virtual pages that share one tag, with one physical frame for the even page and a second for the odd page. The page size of each slot is set by its own size mask, from 4 KB per page upward; each set mask bit doubles the page.

Software fills a slot through a synchronous write port by giving a slot index and the slot contents. The lookup port is purely combinational: it takes a virtual address, the current 8-bit address-space tag and a store/load flag. It returns the physical address, a write-permission flag and a 2-bit outcome code. Address region decoding, trap dispatch and victim selection belong to the surrounding logic.

Top module: `tlb_pair_lookup`

## Requirements
- R1: After reset every slot holds all-zero fields with both valid bits clear, so a lookup whose address lies in 0x0000_0000..0x0000_1FFF with tag 0 returns outcome 2 (invalid), and any non-zero tag returns outcome 1 (miss).
- R2: A slot takes part in a lookup only when its shared flag is set or its 8-bit tag equals the lookup tag.
- R3: A slot's tag compare covers address bits at and above the page-pair boundary. The effective mask is the slot's size mask ORed with 0x1FFF, and bits under the effective mask are left out of the compare.
- R4: The half (even=0, odd=1) is taken from the address bit at the most significant set position of the effective mask (bit 12 for 4 KB pages).
- R5: When the selected half's valid bit is clear, the outcome is 2 (invalid) for both loads and stores.
- R6: A store (lk_write=1) to a valid half whose dirty bit is clear returns outcome 3 (modify fault); a load from a valid half returns outcome 0 (hit) whatever the dirty bit.
- R7: On outcome 0 the physical address is {frame,12'b0} of the selected half ORed with the address bits under the effective mask shifted right by one, and lk_writable equals that half's dirty bit; on every other outcome lk_pa and lk_writable are 0.
- R8: When no slot takes part, the outcome is 1 (miss).
- R9: When several slots match, the lowest-index slot alone decides the outcome and address.
- R10: A slot write is seen by lookups from the clock edge that captures it onward, not before; with wr_en low the clock edge leaves every slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W | Slot index to write |
| wr_vpn | input | VA_W | Virtual tag; bits under the effective mask are ignored |
| wr_pmask | input | VA_W | Size mask, contiguous ones from bit 13 upward |
| wr_asid | input | ASID_W | Address-space tag of the slot |
| wr_global | input | 1 | Shared flag, tag ignored when set |
| wr_pfn0 | input | PFN_W | Even-page frame number |
| wr_pfn1 | input | PFN_W | Odd-page frame number |
| wr_v0 | input | 1 | Even-page valid |
| wr_d0 | input | 1 | Even-page dirty (writable) |
| wr_v1 | input | 1 | Odd-page valid |
| wr_d1 | input | 1 | Odd-page dirty (writable) |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Current address-space tag |
| lk_write | input | 1 | 1 for store, 0 for load |
| lk_pa | output | PA_W | Translated physical address |
| lk_writable | output | 1 | Write permission of the hit half |
| lk_result | output | 2 | 0 hit, 1 miss, 2 invalid, 3 modify fault |

## Verification
Slots of 4 KB, 16 KB, 1 MB and 16 MB pages are loaded, with shared and private tags and a duplicate of one slot at a higher index. Addresses are swept with a coarse stride that crosses page-pair and half boundaries of the large pages, and a fine stride inside 4 KB pairs. Each address is tried under four tags, as load and as store. The tag sweep separates shared from private matching, the strides separate correct mask handling from fixed 4 KB behaviour, and load against store separates the modify fault from a hit. Directed cases cover the reset contents, the timing of a write, a suppressed write and lowest-index priority.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      TLB_HIT   = 2'd0,
      TLB_MISS  = 2'd1,
      TLB_INVAL = 2'd2,
      TLB_MODF  = 2'd3
   } tlb_res_e;

   localparam int PAIR_LSB  = 13;
   localparam int FRAME_LSB = 12;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int VA_W    = 32,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [VA_W-1:0]               wr_vpn,
   input  logic [VA_W-1:0]               wr_pmask,
   input  logic [ASID_W-1:0]             wr_asid,
   input  logic                          wr_global,
   input  logic [PFN_W-1:0]              wr_pfn0,
   input  logic [PFN_W-1:0]              wr_pfn1,
   input  logic                          wr_v0,
   input  logic                          wr_d0,
   input  logic                          wr_v1,
   input  logic                          wr_d1,
   output logic [ENTRIES-1:0][VA_W-1:0]  s_vpn,
   output logic [ENTRIES-1:0][VA_W-1:0]  s_pmask,
   output logic [ENTRIES-1:0][ASID_W-1:0] s_asid,
   output logic [ENTRIES-1:0]            s_glob,
   output logic [ENTRIES-1:0][PFN_W-1:0] s_pfn0,
   output logic [ENTRIES-1:0][PFN_W-1:0] s_pfn1,
   output logic [ENTRIES-1:0][1:0]       s_valid,
   output logic [ENTRIES-1:0][1:0]       s_dirty
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_vpn[g]   <= '0;
            s_pmask[g] <= '0;
            s_asid[g]  <= '0;
            s_glob[g]  <= 1'b0;
            s_pfn0[g]  <= '0;
            s_pfn1[g]  <= '0;
            s_valid[g] <= 2'b00;
            s_dirty[g] <= 2'b00;
         end else if (sel) begin
            s_vpn[g]   <= wr_vpn;
            s_pmask[g] <= wr_pmask;
            s_asid[g]  <= wr_asid;
            s_glob[g]  <= wr_global;
            s_pfn0[g]  <= wr_pfn0;
            s_pfn1[g]  <= wr_pfn1;
            s_valid[g] <= {wr_v1, wr_v0};
            s_dirty[g] <= {wr_d1, wr_d0};
         end
      end
   end
endmodule

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
   import tlb_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int PFN_W  = 20,
   parameter int ASID_W = 8
) (
   input  logic [VA_W-1:0]   s_vpn,
   input  logic [VA_W-1:0]   s_pmask,
   input  logic [ASID_W-1:0] s_asid,
   input  logic              s_glob,
   input  logic [PFN_W-1:0]  s_pfn0,
   input  logic [PFN_W-1:0]  s_pfn1,
   input  logic [1:0]        s_valid,
   input  logic [1:0]        s_dirty,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   output logic              hit,
   output logic [1:0]        code,
   output logic [PA_W-1:0]   pa,
   output logic              wrbl
);
   localparam logic [VA_W-1:0] LOW_ONES = VA_W'((64'd1 << PAIR_LSB) - 64'd1);

   logic [VA_W-1:0] emask, half_bit, offs;
   logic            odd, tag_eq, id_eq, v_sel, d_sel;
   logic [PFN_W-1:0] pfn_sel;
   tlb_res_e        res;

   always_comb begin
      emask    = s_pmask | LOW_ONES;
      half_bit = emask & ~(emask >> 1);
      odd      = |(lk_va & half_bit);
      tag_eq   = ((lk_va ^ s_vpn) & ~emask) == '0;
      id_eq    = s_glob || (s_asid == lk_asid);
      hit      = tag_eq && id_eq;
      v_sel    = odd ? s_valid[1] : s_valid[0];
      d_sel    = odd ? s_dirty[1] : s_dirty[0];
      pfn_sel  = odd ? s_pfn1 : s_pfn0;
      offs     = lk_va & (emask >> 1);
      if (!v_sel)                 res = TLB_INVAL;
      else if (lk_write && !d_sel) res = TLB_MODF;
      else                        res = TLB_HIT;
      code = res;
      if (res == TLB_HIT) begin
         pa   = {pfn_sel, {FRAME_LSB{1'b0}}} | PA_W'(offs);
         wrbl = d_sel;
      end else begin
         pa   = '0;
         wrbl = 1'b0;
      end
   end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int ENTRIES = 16
) (
   input  logic [ENTRIES-1:0] hits,
   output logic [ENTRIES-1:0] sel_oh,
   output logic               any
);
   assign sel_oh = hits & (~hits + ENTRIES'(1));
   assign any    = |hits;
endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32,
   parameter int ASID_W  = 8,
   parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   parameter int PFN_W   = PA_W - FRAME_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VA_W-1:0]   wr_vpn,
   input  logic [VA_W-1:0]   wr_pmask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic [PFN_W-1:0]  wr_pfn0,
   input  logic [PFN_W-1:0]  wr_pfn1,
   input  logic              wr_v0,
   input  logic              wr_d0,
   input  logic              wr_v1,
   input  logic              wr_d1,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   output logic [PA_W-1:0]   lk_pa,
   output logic              lk_writable,
   output logic [1:0]        lk_result
);
   if (ENTRIES < 1)              begin : g_bad_n   $error("ENTRIES must be at least 1"); end
   if (VA_W <= PAIR_LSB)         begin : g_bad_va  $error("VA_W too small for a page pair"); end
   if (PA_W <= FRAME_LSB)        begin : g_bad_pa  $error("PA_W too small for a frame"); end
   if (ASID_W < 1)               begin : g_bad_id  $error("ASID_W must be at least 1"); end
   if (PFN_W != PA_W - FRAME_LSB) begin : g_bad_pf $error("PFN_W must equal PA_W-12"); end
   if ((1 << IDX_W) < ENTRIES)   begin : g_bad_ix  $error("IDX_W cannot address all slots"); end

   logic [ENTRIES-1:0][VA_W-1:0]   s_vpn, s_pmask;
   logic [ENTRIES-1:0][ASID_W-1:0] s_asid;
   logic [ENTRIES-1:0]             s_glob;
   logic [ENTRIES-1:0][PFN_W-1:0]  s_pfn0, s_pfn1;
   logic [ENTRIES-1:0][1:0]        s_valid, s_dirty;

   logic [ENTRIES-1:0]             hits, sel_oh, wrbls;
   logic [ENTRIES-1:0][1:0]        codes;
   logic [ENTRIES-1:0][PA_W-1:0]   pas;
   logic                           any;

   tlb_entry_store #(
      .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VA_W(VA_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_vpn(wr_vpn), .wr_pmask(wr_pmask), .wr_asid(wr_asid), .wr_global(wr_global),
      .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1), .wr_v0(wr_v0), .wr_d0(wr_d0),
      .wr_v1(wr_v1), .wr_d1(wr_d1),
      .s_vpn(s_vpn), .s_pmask(s_pmask), .s_asid(s_asid), .s_glob(s_glob),
      .s_pfn0(s_pfn0), .s_pfn1(s_pfn1), .s_valid(s_valid), .s_dirty(s_dirty)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
      tlb_match_cell #(
         .VA_W(VA_W), .PA_W(PA_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
      ) u_cell (
         .s_vpn(s_vpn[g]), .s_pmask(s_pmask[g]), .s_asid(s_asid[g]), .s_glob(s_glob[g]),
         .s_pfn0(s_pfn0[g]), .s_pfn1(s_pfn1[g]), .s_valid(s_valid[g]), .s_dirty(s_dirty[g]),
         .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
         .hit(hits[g]), .code(codes[g]), .pa(pas[g]), .wrbl(wrbls[g])
      );
   end

   tlb_first_hit #(.ENTRIES(ENTRIES)) u_sel (
      .hits(hits), .sel_oh(sel_oh), .any(any)
   );

   always_comb begin
      logic [1:0]      c_acc;
      logic [PA_W-1:0] p_acc;
      logic            w_acc;
      c_acc = '0;
      p_acc = '0;
      w_acc = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         c_acc = c_acc | (codes[i] & {2{sel_oh[i]}});
         p_acc = p_acc | (pas[i] & {PA_W{sel_oh[i]}});
         w_acc = w_acc | (wrbls[i] & sel_oh[i]);
      end
      lk_result   = any ? c_acc : TLB_MISS;
      lk_pa       = p_acc;
      lk_writable = w_acc;
   end
endmodule

// File: rtl/tlb_pair_lookup_chk.sv
module tlb_pair_lookup_chk #(
   parameter int ENTRIES = 16,
   parameter int VA_W    = 32,
   parameter int PA_W    = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [VA_W-1:0]    lk_va,
   input logic               lk_write,
   input logic [PA_W-1:0]    lk_pa,
   input logic               lk_writable,
   input logic [1:0]         lk_result,
   input logic [ENTRIES-1:0] sel_oh
);
   AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_result != 2'd0) |-> (lk_pa == '0 && !lk_writable)); // R7
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_result == 2'd0) |-> (lk_pa[11:0] == lk_va[11:0])); // R7
   AST_MODIFY_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_result == 2'd3) |-> lk_write); // R6
   AST_STORE_HIT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_result == 2'd0 && lk_write) |-> lk_writable); // R6
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_oh)); // R9
   AST_MISS_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_result == 2'd1) |-> (sel_oh == '0)); // R8
endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk #(
   .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_write(lk_write), .lk_pa(lk_pa),
   .lk_writable(lk_writable), .lk_result(lk_result), .sel_oh(sel_oh)
);

// File: tb/tlb_pair_lookup_tb.sv
module tlb_pair_lookup_tb;
   localparam int N = 16;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_vpn = '0, wr_pmask = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0;
   logic [19:0] wr_pfn0 = '0, wr_pfn1 = '0;
   logic        wr_v0 = 0, wr_d0 = 0, wr_v1 = 0, wr_d1 = 0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_write = 1'b0;
   logic [31:0] lk_pa;
   logic        lk_writable;
   logic [1:0]  lk_result;

   int errors = 0, checks = 0;

   logic [31:0] m_vpn [N], m_pm [N];
   logic [7:0]  m_asid[N];
   logic        m_g   [N];
   logic [19:0] m_pf0 [N], m_pf1[N];
   logic [1:0]  m_v   [N], m_d[N];

   always #4 clk = ~clk;

   tlb_pair_lookup u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
      .wr_pmask(wr_pmask), .wr_asid(wr_asid), .wr_global(wr_global),
      .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1), .wr_v0(wr_v0), .wr_d0(wr_d0),
      .wr_v1(wr_v1), .wr_d1(wr_d1), .lk_va(lk_va), .lk_asid(lk_asid),
      .lk_write(lk_write), .lk_pa(lk_pa), .lk_writable(lk_writable), .lk_result(lk_result)
   );

   task automatic model(input logic [31:0] va, input logic [7:0] id, input logic wr,
                        output logic [1:0] r, output logic [31:0] pa, output logic w);
      r = 2'd1; pa = '0; w = 1'b0;
      for (int i = 0; i < N; i++) begin
         logic [31:0] em;
         int hb;
         logic odd;
         em = m_pm[i] | 32'h1FFF;
         hb = 12;
         for (int b = 12; b < 32; b++) if (em[b]) hb = b;
         if ((m_g[i] || m_asid[i] == id) && ((va >> (hb + 1)) == (m_vpn[i] >> (hb + 1)))) begin
            odd = va[hb];
            if (!m_v[i][odd]) r = 2'd2;
            else if (wr && !m_d[i][odd]) r = 2'd3;
            else begin
               r  = 2'd0;
               pa = ({(odd ? m_pf1[i] : m_pf0[i]), 12'h000}) | (va % (32'd1 << hb));
               w  = m_d[i][odd];
            end
            return;
         end
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] va, input logic [7:0] id,
                      input logic wr);
      logic [1:0] er; logic [31:0] ep; logic ew;
      string t;
      lk_va = va; lk_asid = id; lk_write = wr;
      #1;
      model(va, id, wr, er, ep, ew);
      t = tag;
      if (t == "") t = (er == 0) ? "R7" : (er == 1) ? "R8" : (er == 2) ? "R5" : "R6";
      checks++;
      if (lk_result !== er || lk_pa !== ep || lk_writable !== ew) begin
         errors++;
         $display("FAIL %s va=%h asid=%0d wr=%0d: got res=%0d pa=%h w=%0d, expected res=%0d pa=%h w=%0d",
                  t, va, id, wr, lk_result, lk_pa, lk_writable, er, ep, ew);
      end
   endtask

   task automatic prog(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                       input logic [7:0] id, input logic g, input logic [19:0] f0,
                       input logic [19:0] f1, input logic v0, input logic d0,
                       input logic v1, input logic d1);
      @(negedge clk);
      wr_en = 1; wr_idx = 4'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = id;
      wr_global = g; wr_pfn0 = f0; wr_pfn1 = f1; wr_v0 = v0; wr_d0 = d0; wr_v1 = v1; wr_d1 = d1;
      @(posedge clk);
      m_vpn[idx] = vpn; m_pm[idx] = pm; m_asid[idx] = id; m_g[idx] = g;
      m_pf0[idx] = f0; m_pf1[idx] = f1; m_v[idx] = {v1, v0}; m_d[idx] = {d1, d0};
      @(negedge clk);
      wr_en = 0;
   endtask

   initial begin
      #1600000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_vpn[i] = '0; m_pm[i] = '0; m_asid[i] = '0; m_g[i] = 0;
         m_pf0[i] = '0; m_pf1[i] = '0; m_v[i] = '0; m_d[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset contents
      chk("R1", 32'h0000_0AB0, 8'd0, 0);
      chk("R1", 32'h0000_1AB0, 8'd0, 1);
      chk("R1", 32'h0000_0AB0, 8'd3, 0);

      prog(0,  32'h0040_0000, 32'h0,         8'd1, 0, 20'h12345, 20'h0ABCD, 1, 1, 1, 0);
      prog(1,  32'h1000_0000, 32'h0000_6000, 8'd9, 1, 20'h20000, 20'h20008, 1, 0, 1, 1);
      prog(2,  32'h0800_0000, 32'h001F_E000, 8'd2, 0, 20'h40000, 20'h50000, 1, 1, 0, 0);
      prog(3,  32'h0040_0000, 32'h0,         8'd1, 0, 20'h77000, 20'h78000, 1, 1, 1, 1);
      prog(5,  32'h2000_0000, 32'h01FF_E000, 8'd0, 1, 20'h80000, 20'h81000, 1, 1, 1, 1);
      prog(15, 32'h3000_0000, 32'h0,         8'd3, 0, 20'hFFFFE, 20'hFFFFF, 1, 1, 1, 1);

      // R2: shared vs private tag
      chk("R2", 32'h1000_1234, 8'd7, 0);
      chk("R2", 32'h0040_0123, 8'd2, 0);
      // R3: large page tag compare
      chk("R3", 32'h080F_F123, 8'd2, 0);
      chk("R3", 32'h0820_0000, 8'd2, 0);
      // R4: odd half of a 4 KB pair
      chk("R4", 32'h0040_1ABC, 8'd1, 0);
      chk("R4", 32'h1000_4321, 8'd0, 1);
      // R9: slot 3 duplicates slot 0, slot 0 must decide
      chk("R9", 32'h0040_0010, 8'd1, 1);
      chk("R9", 32'h0040_1010, 8'd1, 1);

      // sweep
      begin
         logic [31:0] bases [6];
         bases = '{32'h0040_0000, 32'h1000_0000, 32'h0800_0000,
                   32'h2000_0000, 32'h3000_0000, 32'h0000_0000};
         foreach (bases[b]) begin
            for (int k = 0; k < 16; k++) begin
               for (int a = 0; a < 4; a++) begin
                  for (int w = 0; w < 2; w++) begin
                     chk("", bases[b] + 32'(k) * 32'h0019_3C4B, 8'(a), w[0]);
                     chk("", bases[b] + 32'(k) * 32'h0000_0C01, 8'(a), w[0]);
                  end
               end
            end
         end
      end

      // R10: write timing and suppressed write
      @(negedge clk);
      wr_en = 1; wr_idx = 4'd6; wr_vpn = 32'h5000_0000; wr_pmask = 0; wr_asid = 0;
      wr_global = 1; wr_pfn0 = 20'h00111; wr_pfn1 = 20'h00222;
      wr_v0 = 1; wr_d0 = 1; wr_v1 = 1; wr_d1 = 1;
      chk("R10", 32'h5000_0010, 8'd4, 0);
      @(posedge clk);
      m_vpn[6] = 32'h5000_0000; m_pm[6] = 0; m_asid[6] = 0; m_g[6] = 1;
      m_pf0[6] = 20'h00111; m_pf1[6] = 20'h00222; m_v[6] = 2'b11; m_d[6] = 2'b11;
      @(negedge clk);
      wr_en = 0;
      chk("R10", 32'h5000_0010, 8'd4, 0);
      wr_pfn0 = 20'h00999; wr_v0 = 0; wr_vpn = 32'h6000_0000;
      @(posedge clk);
      @(negedge clk);
      chk("R10", 32'h5000_0010, 8'd4, 1);
      chk("R10", 32'h6000_0010, 8'd4, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule